// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level translation tree held in memory. A request carries the linear address. The walker reads one directory entry at the directory base frame, and then, when needed, one table entry at the frame that the directory entry names. It issues these reads one at a time through a request/ready/data-valid read port, so the memory may take any number of cycles to answer.

The walk ends early in two cases. A directory or table entry whose present flag is clear ends the walk with a fault. When large-page mode is on, a directory entry that carries the large-page flag yields a 4 MiB page after a single read. The result is a physical address plus a fault flag. A one-cycle done pulse marks it, and the result stays on the outputs until the next walk finishes. A request that arrives while a walk is running is dropped.

Top module: `pt_walk2`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are 0 and `phys` is 0.
- R2: The first read of every walk goes to `{dir_frame, 12'h000} + 4 * req_lin[31:22]`, using the base and address captured when the request was accepted.
- R3: The second read of a walk goes to `{pde[31:12], 12'h000} + 4 * req_lin[21:12]`, where `pde` is the word returned by the first read.
- R4: If both entries have bit 0 (present) set and no large page applies, the walk ends with `fault`=0 and `phys = {pte[31:12], req_lin[11:0]}`, after exactly two reads. Flag bits 11:1 of an entry do not change the address.
- R5: A directory entry with bit 0 clear ends the walk after one read with `fault`=1 and `phys`=0, even when its bit 7 is set.
- R6: A table entry with bit 0 clear ends the walk after two reads with `fault`=1 and `phys`=0.
- R7: With `big_en`=1, a present directory entry with bit 7 set ends the walk after one read with `fault`=0 and `phys = {pde[31:22], req_lin[21:0]}`.
- R8: With `big_en`=0, bit 7 of a directory entry is ignored and the walk reads the table entry as in R3 and R4. With `big_en`=1, a directory entry with bit 7 clear also takes the two-read walk.
- R9: `req_valid` is taken only while `busy` is 0. `busy` rises on the next edge and stays high until the walk ends. A `req_valid` seen while busy starts no walk and does not change the result.
- R10: `done` is high for exactly one cycle per walk. `phys` and `fault` hold their values until the next `done`.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ready` is seen. Read data is taken only on `mem_rvalid`. At most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Starts a walk when idle |
| req_lin | input | 32 | Linear address to translate |
| dir_frame | input | 20 | Frame number of the directory |
| big_en | input | 1 | Enables 4 MiB pages via directory bit 7 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Last walk hit a non-present entry |
| phys | output | 32 | Last translated physical address |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 32 | Read address of the entry |
| mem_ready | input | 1 | Memory accepts the read request |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Entry word read |

## Verification
Every translation is compared against a sparse memory image that the bench holds, and the memory answers with varying delay. The addresses span present and absent directory slots, present and absent table slots at index 0, a middle index and the last index, and a large-page slot tried with the mode off and on. These cases tell a one-read walk from a two-read walk, a fault at the directory level from a fault at the table level, and a large page from a small one. The number of reads and the first read address are checked on each walk. Separate tests show that a request during a walk is dropped and that the result holds between walks.

// File: rtl/pt_walk2.sv
module pt_walk2 #(
  parameter int LA_W     = 32,
  parameter int DIR_W    = 10,
  parameter int OFS_W    = 12,
  parameter int PRES_BIT = 0,
  parameter int BIG_BIT  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [LA_W-1:0]         req_lin,
  input  logic [LA_W-OFS_W-1:0]   dir_frame,
  input  logic                    big_en,
  output logic                    busy,
  output logic                    done,
  output logic                    fault,
  output logic [LA_W-1:0]         phys,
  output logic                    mem_req,
  output logic [LA_W-1:0]         mem_addr,
  input  logic                    mem_ready,
  input  logic                    mem_rvalid,
  input  logic [LA_W-1:0]         mem_rdata
);
  localparam int FRM_W  = LA_W - OFS_W;
  localparam int TBL_W  = LA_W - DIR_W - OFS_W;
  localparam int BOFS_W = LA_W - DIR_W;
  localparam int ENT_SH = 2;

  typedef enum logic [2:0] {S_IDLE, S_DRQ, S_DWT, S_TRQ, S_TWT} st_t;
  st_t st;

  logic [LA_W-1:0]  lin_q;
  logic [FRM_W-1:0] dfrm_q, tfrm_q;
  logic             big_q;

  wire [DIR_W-1:0] dir_idx = lin_q[LA_W-1 -: DIR_W];
  wire [TBL_W-1:0] tbl_idx = lin_q[OFS_W +: TBL_W];
  wire [LA_W-1:0]  d_addr  = {dfrm_q, {OFS_W{1'b0}}} + LA_W'({dir_idx, {ENT_SH{1'b0}}});
  wire [LA_W-1:0]  t_addr  = {tfrm_q, {OFS_W{1'b0}}} + LA_W'({tbl_idx, {ENT_SH{1'b0}}});
  wire             ent_ok  = mem_rdata[PRES_BIT];
  wire             is_big  = big_q && mem_rdata[BIG_BIT];

  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_DRQ) || (st == S_TRQ);
  assign mem_addr = (st == S_TRQ) ? t_addr : d_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lin_q  <= '0;
      dfrm_q <= '0;
      tfrm_q <= '0;
      big_q  <= 1'b0;
      done   <= 1'b0;
      fault  <= 1'b0;
      phys   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q  <= req_lin;
          dfrm_q <= dir_frame;
          big_q  <= big_en;
          st     <= S_DRQ;
        end
        S_DRQ: if (mem_ready) st <= S_DWT;
        S_DWT: if (mem_rvalid) begin
          if (!ent_ok) begin
            done  <= 1'b1;
            fault <= 1'b1;
            phys  <= '0;
            st    <= S_IDLE;
          end else if (is_big) begin
            done  <= 1'b1;
            fault <= 1'b0;
            phys  <= {mem_rdata[LA_W-1 -: DIR_W], lin_q[BOFS_W-1:0]};
            st    <= S_IDLE;
          end else begin
            tfrm_q <= mem_rdata[LA_W-1 -: FRM_W];
            st     <= S_TRQ;
          end
        end
        S_TRQ: if (mem_ready) st <= S_TWT;
        S_TWT: if (mem_rvalid) begin
          done  <= 1'b1;
          fault <= !ent_ok;
          phys  <= ent_ok ? {mem_rdata[LA_W-1 -: FRM_W], lin_q[OFS_W-1:0]} : '0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [1:0] rd_n;
  always_ff @(posedge clk) begin
    if (!rst_n) rd_n <= '0;
    else if (!busy && req_valid) rd_n <= '0;
    else if (mem_req && mem_ready) rd_n <= rd_n + 2'd1;
  end

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (phys == '0));

  // R9
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R4
  read_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |-> (rd_n < 2'd2));

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(phys) && $stable(fault)));
endmodule

// File: tb/pt_walk2_tb_top.sv
module pt_walk2_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [31:0] req_lin = 0;
  logic [19:0] dir_frame = 20'h00100;
  logic big_en = 0;
  logic busy, done, fault, mem_req;
  logic [31:0] phys, mem_addr;
  logic mem_ready = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  always #5 clk = ~clk;

  pt_walk2 dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .dir_frame(dir_frame), .big_en(big_en), .busy(busy), .done(done),
    .fault(fault), .phys(phys), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0, fails = 0;
  int nreads = 0;
  logic [31:0] first_addr = 0;
  logic [31:0] lcg = 32'h1234_5678;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a)
      32'h0010_0000: return 32'h1000_0001;
      32'h0010_0008: return 32'h8000_0061;
      32'h0010_000C: return 32'h5540_0081;
      32'h0010_0010: return 32'h0000_0080;
      32'h1000_0000: return 32'h0000_1001;
      32'h1000_0008: return 32'h0000_DFE1;
      32'h1000_0FFC: return 32'h0000_5001;
      32'h8000_0000: return 32'h0000_A001;
      32'h8000_0004: return 32'h0000_C021;
      32'h5540_0048: return 32'h0007_7001;
      default:       return 32'h0000_0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  initial begin : responder
    bit pend = 0;
    int wcnt = 1, rcnt = 0;
    logic [31:0] paddr = 0;
    forever begin
      @(negedge clk);
      mem_ready = 0;
      mem_rvalid = 0;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      if (pend) begin
        if (rcnt == 0) begin
          mem_rvalid = 1;
          mem_rdata = mem_word(paddr);
          pend = 0;
        end else rcnt--;
      end else if (mem_req) begin
        if (wcnt == 0) begin
          mem_ready = 1;
          paddr = mem_addr;
          if (nreads == 0) first_addr = mem_addr;
          nreads++;
          pend = 1;
          rcnt = int'(lcg[17:16]);
          wcnt = int'(lcg[21:20]);
        end else wcnt--;
      end
    end
  end

  task automatic walk(input logic [31:0] lin, input bit big, output bit ok);
    @(negedge clk);
    nreads = 0;
    req_lin = lin;
    big_en = big;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  localparam int NV = 12;
  localparam logic [67:0] VEC [NV] = '{
    {32'h0000_0001, 1'b0, 1'b0, 32'h0000_1001, 2'd2},
    {32'h0000_1001, 1'b0, 1'b1, 32'h0000_0000, 2'd2},
    {32'h003F_F001, 1'b0, 1'b0, 32'h0000_5001, 2'd2},
    {32'h0040_0000, 1'b0, 1'b1, 32'h0000_0000, 2'd1},
    {32'h0080_0001, 1'b0, 1'b0, 32'h0000_A001, 2'd2},
    {32'h0080_1004, 1'b0, 1'b0, 32'h0000_C004, 2'd2},
    {32'h0080_2004, 1'b0, 1'b1, 32'h0000_0000, 2'd2},
    {32'h0000_2ABC, 1'b0, 1'b0, 32'h0000_DABC, 2'd2},
    {32'h00C1_2345, 1'b1, 1'b0, 32'h5541_2345, 2'd1},
    {32'h00C1_2345, 1'b0, 1'b0, 32'h0007_7345, 2'd2},
    {32'h0100_0000, 1'b1, 1'b1, 32'h0000_0000, 2'd1},
    {32'h0080_1004, 1'b1, 1'b0, 32'h0000_C004, 2'd2}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    bit ok;
    int dones;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fault && !mem_req, "R1 reset flags", {28'd0, busy, done, fault, mem_req}, 32'd0);
    chk(phys == 0, "R1 reset phys", phys, 32'd0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      logic [31:0] lin, ephys, eda;
      bit big, eflt;
      int erd;
      lin = VEC[v][67:36];
      big = VEC[v][35];
      eflt = VEC[v][34];
      ephys = VEC[v][33:2];
      erd = int'(VEC[v][1:0]);
      eda = 32'h0010_0000 + {20'd0, lin[31:22], 2'b00};
      walk(lin, big, ok);
      chk(ok, "R9 walk completes", {31'd0, ok}, 32'd1);
      chk(first_addr == eda, "R2 directory read address", first_addr, eda);
      if (eflt && erd == 1) chk(fault == 1 && phys == 0, "R5 directory fault", phys, 32'd0);
      else if (eflt)        chk(fault == 1 && phys == 0, "R6 table fault", phys, 32'd0);
      else if (erd == 1)    chk(!fault && phys == ephys, "R7 large page", phys, ephys);
      else                  chk(!fault && phys == ephys, "R4 small page R3 R8", phys, ephys);
      chk(nreads == erd, "R4 read count", nreads, erd);
      @(negedge clk);
      chk(!done, "R10 done single cycle", {31'd0, done}, 32'd0);
    end

    // R10 result held while idle
    repeat (5) @(negedge clk);
    chk(phys == 32'h0000_C004 && !fault, "R10 result holds", phys, 32'h0000_C004);

    // R9 request while busy ignored
    @(negedge clk);
    nreads = 0;
    req_lin = 32'h0080_1004;
    big_en = 0;
    req_valid = 1;
    @(negedge clk);
    req_lin = 32'h0040_0000;
    @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    dones = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk(dones == 1, "R9 single walk for busy request", dones, 32'd1);
    chk(phys == 32'h0000_C004 && !fault, "R9 busy request no effect", phys, 32'h0000_C004);
    chk(nreads == 2 && !busy, "R9 no extra reads", nreads, 32'd2);

    // R11 varying latency already applied; check address of second read path
    dir_frame = 20'h00100;
    walk(32'h003F_F001, 0, ok);
    chk(ok && phys == 32'h0000_5001, "R11 variable latency walk", phys, 32'h0000_5001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule